// File: doc/BRIEF.md
# Horizontal Sync Pulse Generator

This block drives the active-low horizontal sync pin of a video encoder when the encoder is the timing master. It watches the horizontal pixel counter that the rest of the encoder keeps, and it pulls the pin low once per line. By default the pulse starts at pixel 0 and has the standard width of 4.7 µs. The width in pixel clocks is worked out at elaboration from the pixel-clock frequency parameter.

An adjust bit switches the block to programmed edges. The host then gives two 10-bit pixel positions. The pin goes low at the falling-edge position and returns high at the rising-edge position, and the window may wrap past the end of the line. A suppression bit keeps the pin high for the whole vertical blanking interval, so no horizontal pulses appear there. A delay bit moves the whole pulse later by a fixed number of pixel clocks. When the encoder is a timing slave, the pin stays high.

Top module: `hsync_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, hsync_n is 1.
- R2: With adj_en=0, hsync_n is 0 for pixel counts 0 to DEF_W-1 and 1 at all other counts. DEF_W = round(4.7e-6 × PIX_HZ), which is 63 clocks at the default PIX_HZ of 13.5 MHz.
- R3: With adj_en=1 and fall_pos < rise_pos, hsync_n is 0 exactly when fall_pos ≤ pixel count < rise_pos.
- R4: With adj_en=1 and fall_pos > rise_pos, the window wraps: hsync_n is 0 when pixel count ≥ fall_pos or pixel count < rise_pos. With fall_pos = rise_pos, hsync_n stays 1.
- R5: Edge positions use all 10 bits, so positions above 255, with bits 9:8 set, are honoured.
- R6: With vbi_sup_en=1 and in_vbi=1, hsync_n is 1. With vbi_sup_en=1 and in_vbi=0, or with vbi_sup_en=0, pulses are produced as usual.
- R7: With dly_en=1, the output pattern is the undelayed pattern moved DLY_CLKS pixel clocks later (4 by default).
- R8: With master_en=0 (slave mode), hsync_n is 1 one clock later and stays 1.
- R9: Without delay, hsync_n reflects the pixel count and configuration present two rising clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = timing master, 0 = slave (pin held high) |
| adj_en | input | 1 | 1 = programmed edges, 0 = default-width pulse |
| fall_pos | input | POSW (10) | Pixel position of the falling edge |
| rise_pos | input | POSW (10) | Pixel position of the rising edge |
| vbi_sup_en | input | 1 | Suppress sync during vertical blanking |
| dly_en | input | 1 | Delay the pulse by DLY_CLKS pixel clocks |
| in_vbi | input | 1 | Current line lies in vertical blanking |
| pix_cnt | input | PXW (11) | Horizontal pixel counter |
| hsync_n | output | 1 | Active-low horizontal sync |

## Verification
On every cycle, the in-line properties check the following. A pixel inside a programmed window, or pixel 0 in default mode, drives the first stage low. Equal edge positions and blanking-line suppression hold that stage high. Slave mode forces the pin high one cycle later. The directed scenarios check what single-cycle properties cannot. They compare the pin, cycle by cycle over whole lines, with a bench model, which covers the default width count, wrapped windows, high-bit positions and the exact shift the delay option adds.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

  // Number of pixel clocks in a 4.7 us pulse, rounded to nearest.
  function automatic int pulse_clocks(input longint hz);
    return int'((hz * 64'd47 + 64'd5_000_000) / 64'd10_000_000);
  endfunction

  typedef enum logic [1:0] {
    WIN_DEFAULT = 2'd0,
    WIN_SPAN    = 2'd1,
    WIN_WRAP    = 2'd2,
    WIN_EMPTY   = 2'd3
  } win_kind_e;

endpackage

// File: rtl/hsync_window.sv
module hsync_window #(
  parameter int PXW   = 11,
  parameter int POSW  = 10,
  parameter int DEF_W = 63
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PXW-1:0]  pix,
  input  logic            adj_en,
  input  logic [POSW-1:0] fall_pos,
  input  logic [POSW-1:0] rise_pos,
  input  logic            vbi_sup_en,
  input  logic            in_vbi,
  output logic            raw_q
);
  import hsync_pkg::*;

  localparam int CW = (PXW > POSW) ? PXW : POSW;
  localparam logic [CW-1:0] DEF_END = CW'(DEF_W);

  logic [CW-1:0] p_w, f_w, r_w;
  win_kind_e     kind;
  logic          in_win;
  logic          raw_d;

  assign p_w = CW'(pix);
  assign f_w = CW'(fall_pos);
  assign r_w = CW'(rise_pos);

  always_comb begin
    if (!adj_en)           kind = WIN_DEFAULT;
    else if (f_w < r_w)    kind = WIN_SPAN;
    else if (f_w > r_w)    kind = WIN_WRAP;
    else                   kind = WIN_EMPTY;
  end

  always_comb begin
    unique case (kind)
      WIN_DEFAULT: in_win = (p_w < DEF_END);
      WIN_SPAN:    in_win = (p_w >= f_w) && (p_w < r_w);
      WIN_WRAP:    in_win = (p_w >= f_w) || (p_w < r_w);
      default:     in_win = 1'b0;
    endcase
  end

  always_comb begin
    raw_d = ~in_win;
    if (vbi_sup_en && in_vbi) raw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b1;
    else        raw_q <= raw_d;
  end

  // R3: a pixel strictly inside a programmed span pulls the stage low
  a_r3_span_low: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_en && (f_w < r_w) && (p_w >= f_w) && (p_w < r_w) && !(vbi_sup_en && in_vbi))
      |=> !raw_q);

  // R2: pixel 0 in default mode is always inside the pulse
  a_r2_default_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_en && (p_w == '0) && !(vbi_sup_en && in_vbi)) |=> !raw_q);

  // R4: equal edge positions never produce a pulse
  a_r4_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_en && (f_w == r_w)) |=> raw_q);

  // R6: blanking-line suppression keeps the stage high
  a_r6_vbi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vbi_sup_en && in_vbi) |=> raw_q);

endmodule

// File: rtl/hsync_delay.sv
module hsync_delay #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stg_q;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      logic stg_d;
      if (gi == 0) begin : g_first
        assign stg_d = d;
      end else begin : g_next
        assign stg_d = stg_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[gi] <= 1'b1;
        else        stg_q[gi] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[DEPTH-1];

endmodule

// File: rtl/hsync_gen.sv
module hsync_gen #(
  parameter longint PIX_HZ   = 13_500_000,
  parameter int     PXW      = 11,
  parameter int     POSW     = 10,
  parameter int     DLY_CLKS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master_en,
  input  logic            adj_en,
  input  logic [POSW-1:0] fall_pos,
  input  logic [POSW-1:0] rise_pos,
  input  logic            vbi_sup_en,
  input  logic            dly_en,
  input  logic            in_vbi,
  input  logic [PXW-1:0]  pix_cnt,
  output logic            hsync_n
);
  import hsync_pkg::*;

  localparam int DEF_W = pulse_clocks(PIX_HZ);

  logic raw_q;
  logic tap;
  logic out_d;
  logic out_q;

  hsync_window #(
    .PXW   (PXW),
    .POSW  (POSW),
    .DEF_W (DEF_W)
  ) win_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix        (pix_cnt),
    .adj_en     (adj_en),
    .fall_pos   (fall_pos),
    .rise_pos   (rise_pos),
    .vbi_sup_en (vbi_sup_en),
    .in_vbi     (in_vbi),
    .raw_q      (raw_q)
  );

  hsync_delay #(
    .DEPTH (DLY_CLKS)
  ) dly_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_q),
    .q     (tap)
  );

  always_comb begin
    out_d = dly_en ? tap : raw_q;
    if (!master_en) out_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b1;
    else        out_q <= out_d;
  end

  assign hsync_n = out_q;

  // R8: slave mode holds the pin high from the next cycle
  a_r8_slave_high: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> hsync_n);

  // R9: undelayed master output follows the first stage by one clock
  a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && !dly_en) |=> (hsync_n == $past(raw_q)));

endmodule

// File: tb/hsync_gen_tb_top.sv
module hsync_gen_tb_top;
  localparam int     CLK_PERIOD = 10;
  localparam longint PIX_HZ     = 13_500_000;
  localparam int     DLY        = 4;
  localparam int     LINE_LEN   = 858;
  localparam int     DEFW       = int'((PIX_HZ * 47 + 5_000_000) / 10_000_000);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        master_en, adj_en, vbi_sup_en, dly_en, in_vbi;
  logic [9:0]  fall_pos, rise_pos;
  logic [10:0] pix_cnt;
  logic        hsync_n;

  int tests_run = 0;
  int tests_failed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsync_gen #(.PIX_HZ(PIX_HZ), .PXW(11), .POSW(10), .DLY_CLKS(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .adj_en(adj_en),
    .fall_pos(fall_pos), .rise_pos(rise_pos), .vbi_sup_en(vbi_sup_en),
    .dly_en(dly_en), .in_vbi(in_vbi), .pix_cnt(pix_cnt), .hsync_n(hsync_n)
  );

  function automatic logic model(input int p);
    if (!master_en) return 1'b1;
    if (vbi_sup_en && in_vbi) return 1'b1;
    if (!adj_en) return (p < DEFW) ? 1'b0 : 1'b1;
    if (fall_pos < rise_pos) return (p >= fall_pos && p < rise_pos) ? 1'b0 : 1'b1;
    if (fall_pos > rise_pos) return (p >= fall_pos || p < rise_pos) ? 1'b0 : 1'b1;
    return 1'b1;
  endfunction

  // Runs one full line plus warm-up and compares every cycle with the model.
  task automatic run_line(input string req, input string what);
    logic hist [0:15];
    int   lat = 2 + (dly_en ? DLY : 0);
    int   bad = 0;
    for (int c = 0; c < LINE_LEN + lat; c++) begin
      @(negedge clk);
      if (c >= lat && hsync_n !== hist[(c - lat) % 16]) begin
        if (bad == 0)
          $display("FAIL %s %s: cycle %0d actual %b expected %b",
                   req, what, c, hsync_n, hist[(c - lat) % 16]);
        bad++;
      end
      pix_cnt = 11'((c) % LINE_LEN);
      hist[c % 16] = model(c % LINE_LEN);
    end
    tests_run++;
    if (bad != 0) tests_failed++;
  endtask

  task automatic set_cfg(input logic m, input logic a, input logic [9:0] f,
                         input logic [9:0] r, input logic s, input logic d,
                         input logic v);
    @(negedge clk);
    master_en = m; adj_en = a; fall_pos = f; rise_pos = r;
    vbi_sup_en = s; dly_en = d; in_vbi = v;
  endtask

  // R1: reset state
  task automatic t_reset;
    rst_n = 1'b0;
    master_en = 1'b1; adj_en = 1'b0; fall_pos = '0; rise_pos = '0;
    vbi_sup_en = 1'b0; dly_en = 1'b0; in_vbi = 1'b0; pix_cnt = '0;
    repeat (3) @(negedge clk);
    tests_run++;
    if (hsync_n !== 1'b1) begin
      tests_failed++;
      $display("FAIL R1 reset: actual %b expected 1", hsync_n);
    end
    rst_n = 1'b1;
    @(negedge clk);
    tests_run++;
    if (hsync_n !== 1'b1) begin
      tests_failed++;
      $display("FAIL R1 after release: actual %b expected 1", hsync_n);
    end
  endtask

  // R2: default width counted directly at the pin
  task automatic t_default_width;
    int lows = 0;
    set_cfg(1, 0, 0, 0, 0, 0, 0);
    run_line("R2", "default line");
    for (int c = 0; c < LINE_LEN + 2; c++) begin
      @(negedge clk);
      if (c >= 2 && hsync_n === 1'b0) lows++;
      pix_cnt = 11'(c % LINE_LEN);
    end
    tests_run++;
    if (lows != DEFW) begin
      tests_failed++;
      $display("FAIL R2 width: actual %0d expected %0d", lows, DEFW);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    t_reset();
    t_default_width();
    set_cfg(1, 1, 10'd20, 10'd90, 0, 0, 0);   run_line("R3", "span 20..90");
    set_cfg(1, 1, 10'd0, 10'd1, 0, 0, 0);     run_line("R3", "one-pixel span");
    set_cfg(1, 1, 10'd840, 10'd30, 0, 0, 0);  run_line("R4", "wrapped window");
    set_cfg(1, 1, 10'd100, 10'd100, 0, 0, 0); run_line("R4", "equal edges");
    set_cfg(1, 1, 10'd600, 10'd770, 0, 0, 0); run_line("R5", "high-bit span");
    set_cfg(1, 1, 10'd300, 10'd520, 0, 0, 0); run_line("R5", "bit 8 span");
    set_cfg(1, 0, 0, 0, 1, 0, 1);             run_line("R6", "suppressed in vbi");
    set_cfg(1, 1, 10'd40, 10'd80, 1, 0, 1);   run_line("R6", "suppressed adj in vbi");
    set_cfg(1, 0, 0, 0, 1, 0, 0);             run_line("R6", "sup set, active line");
    set_cfg(1, 0, 0, 0, 0, 0, 1);             run_line("R6", "sup clear, vbi line");
    set_cfg(1, 0, 0, 0, 0, 1, 0);             run_line("R7", "delayed default");
    set_cfg(1, 1, 10'd200, 10'd260, 0, 1, 0); run_line("R7", "delayed span");
    set_cfg(0, 0, 0, 0, 0, 0, 0);             run_line("R8", "slave default");
    set_cfg(0, 1, 10'd5, 10'd500, 0, 1, 0);   run_line("R8", "slave adj delayed");
    set_cfg(1, 1, 10'd7, 10'd9, 0, 0, 0);     run_line("R9", "two-clock latency");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule